// File: doc/BRIEF.md
# Zone Access Map Table

This block keeps the access history of a handful of "hot" memory zones for a map-based data prefetcher. Memory is cut into fixed-size zones; each resident zone owns a map holding a 2-bit history state for every cache line inside it. The states record whether a line has been untouched, demanded, prefetched, or prefetched and then demanded. The maps live in a fully associative table that is searched by zone tag.

Every demand access looks up its zone. A resident zone has the demanded line's state advanced. A missing zone takes the table slot that was least recently demanded, and that slot's map starts over with every line untouched. In either case the whole updated map, its zone tag and the demanded line index are handed to a downstream pattern matcher one cycle later. A separate input reports prefetches that have been issued, so that untouched lines of resident zones can be marked as prefetched. The pattern detection, the cache and the memory path sit outside this block.

Top module: `zone_map_table`

## Requirements
- R1: After reset `out_valid` is 0 and no zone is resident, so the first demand to any zone returns a map in which only the demanded line is non-untouched.
- R2: Address fields: the low `OFS_W` bits select a byte inside a line, the next `IDX_W` bits are the line index inside the zone, and the remaining upper bits are the zone tag. Line state codes are untouched=0, demanded=1, prefetched=2, prefetch-used=3, and line i occupies `out_map[2i+1:2i]`.
- R3: A demand on an untouched line turns it demanded. For each cycle with `dem_valid` high, the next cycle has `out_valid` high with that demand's zone tag, line index and the map after this cycle's updates. Without a demand, `out_valid` is low the next cycle.
- R4: A demand on a prefetched line turns it prefetch-used.
- R5: A demand on a line that is demanded or prefetch-used leaves its state as it is.
- R6: A prefetch notice to an untouched line of a resident zone turns it prefetched. A notice to a line in any other state is ignored, and a notice to a zone that is not resident is dropped without allocating a map.
- R7: A demand to a non-resident zone allocates a slot with every line untouched before the demand is applied, so history from an earlier stay of that zone is gone. No zone is ever held in two slots.
- R8: With all slots in use, a demand miss evicts the zone whose last demand is oldest. Prefetch notices do not count as use.
- R9: When a demand and a prefetch notice arrive in the same cycle, the demand is applied first and the notice second, and the output map shows both. On the same line the demand therefore wins.
- R10: A prefetch notice whose zone is evicted by a demand in the same cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dem_valid | input | 1 | A demand access is presented |
| dem_addr | input | ADDR_W | Demand byte address |
| pf_valid | input | 1 | A prefetch-issued notice is presented |
| pf_addr | input | ADDR_W | Byte address of the issued prefetch |
| out_valid | output | 1 | Map output valid, one cycle after a demand |
| out_tag | output | ADDR_W-OFS_W-IDX_W | Zone tag of that demand |
| out_line | output | IDX_W | Line index of that demand within its zone |
| out_map | output | 2*2**IDX_W | Updated map of the zone, two bits per line |

## Verification
The bench builds the table with 4 slots, 8 lines per zone, 4-byte lines and 16-bit addresses. With only four slots, a handful of demands is enough to fill the table, so eviction order, the refusal of prefetch notices to refresh a zone, and an eviction that collides with a prefetch notice all come up in short directed sequences. With eight lines, a pseudo-random stream over six zones visits every state transition many times. Whole maps can also be checked exactly against a reference model.

// File: rtl/zmt_pkg.sv
package zmt_pkg;

  // Per-line history codes.
  localparam logic [1:0] ST_INIT = 2'd0;  // untouched
  localparam logic [1:0] ST_SEEN = 2'd1;  // demanded
  localparam logic [1:0] ST_PFED = 2'd2;  // prefetched, not yet demanded
  localparam logic [1:0] ST_USED = 2'd3;  // prefetched, then demanded

  function automatic logic [1:0] demand_step(input logic [1:0] s);
    logic [1:0] r;
    case (s)
      ST_INIT: r = ST_SEEN;
      ST_PFED: r = ST_USED;
      default: r = s;
    endcase
    return r;
  endfunction

  function automatic logic [1:0] prefetch_step(input logic [1:0] s);
    return (s == ST_INIT) ? ST_PFED : s;
  endfunction

endpackage

// File: rtl/zmt_onehot_mux.sv
module zmt_onehot_mux #(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic [N-1:0]   sel_oh,
  input  logic [N*W-1:0] data_flat,
  output logic [W-1:0]   data_out
);

  always_comb begin
    data_out = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_oh[i]) data_out = data_out | data_flat[i*W +: W];
    end
  end

endmodule

// File: rtl/zmt_lru.sv
module zmt_lru #(
  parameter int N = 52
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         touch_valid,
  input  logic [N-1:0] touch_oh,
  output logic [N-1:0] victim_oh
);

  localparam int RANK_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [RANK_W-1:0] OLDEST = RANK_W'(N - 1);

  logic [RANK_W-1:0] rank_q [N];
  logic [RANK_W-1:0] rank_d [N];
  logic [RANK_W-1:0] touched_rank;

  // Ranks stay a permutation of 0..N-1; 0 is most recent.
  always_comb begin
    touched_rank = '0;
    for (int i = 0; i < N; i++) begin
      if (touch_oh[i]) touched_rank = touched_rank | rank_q[i];
    end
    for (int i = 0; i < N; i++) begin
      rank_d[i] = rank_q[i];
      if (touch_oh[i]) begin
        rank_d[i] = '0;
      end else if (rank_q[i] < touched_rank) begin
        rank_d[i] = rank_q[i] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) rank_q[i] <= RANK_W'(i);
    end else if (touch_valid) begin
      for (int i = 0; i < N; i++) rank_q[i] <= rank_d[i];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_victim
    assign victim_oh[g] = (rank_q[g] == OLDEST);
  end

  // R8: exactly one slot is the eviction candidate
  assert_victim_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(victim_oh));

  // R8: a slot just used is never the next victim
  assert_touched_not_victim_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_valid && $onehot(touch_oh)) |=> ((victim_oh & $past(touch_oh)) == '0));

endmodule

// File: rtl/zmt_entry.sv
module zmt_entry
  import zmt_pkg::*;
#(
  parameter int TAG_W = 18,
  parameter int IDX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dem_valid,
  input  logic [TAG_W-1:0]     dem_tag,
  input  logic [IDX_W-1:0]     dem_idx,
  input  logic                 pf_valid,
  input  logic [TAG_W-1:0]     pf_tag,
  input  logic [IDX_W-1:0]     pf_idx,
  input  logic                 alloc,
  output logic                 dem_hit,
  output logic [2*(1<<IDX_W)-1:0] map_nxt
);

  localparam int LINES = 1 << IDX_W;
  localparam int MAP_W = 2 * LINES;

  logic             valid_q, valid_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic [MAP_W-1:0] map_q;
  logic             pf_hit;
  logic             dem_touch;
  logic             map_en;
  logic [1:0]       cur_dem_st;

  assign dem_hit    = valid_q && (tag_q == dem_tag);
  assign pf_hit     = valid_q && (tag_q == pf_tag) && !alloc;
  assign dem_touch  = dem_valid && (dem_hit || alloc);
  assign map_en     = alloc || dem_touch || (pf_valid && pf_hit);
  assign cur_dem_st = map_q[{dem_idx, 1'b0} +: 2];

  // Demand first, prefetch notice second.
  always_comb begin
    map_nxt = alloc ? '0 : map_q;
    if (dem_touch) begin
      map_nxt[{dem_idx, 1'b0} +: 2] = demand_step(map_nxt[{dem_idx, 1'b0} +: 2]);
    end
    if (pf_valid && pf_hit) begin
      map_nxt[{pf_idx, 1'b0} +: 2] = prefetch_step(map_nxt[{pf_idx, 1'b0} +: 2]);
    end
  end

  always_comb begin
    valid_d = valid_q | alloc;
    tag_d   = alloc ? dem_tag : tag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      map_q   <= '0;
    end else begin
      valid_q <= valid_d;
      tag_q   <= tag_d;
      if (map_en) map_q <= map_nxt;
    end
  end

  // R4: demanded prefetched line becomes prefetch-used
  assert_pf_to_used_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dem_valid && dem_hit && cur_dem_st == ST_PFED)
      |=> (map_q[{$past(dem_idx), 1'b0} +: 2] == ST_USED));

  // R5: demand on demanded or prefetch-used line keeps it
  assert_keep_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dem_valid && dem_hit && (cur_dem_st == ST_SEEN || cur_dem_st == ST_USED))
      |=> (map_q[{$past(dem_idx), 1'b0} +: 2] == $past(cur_dem_st)));

  // R7: a fresh slot holds the new tag and only the demanded line is set
  assert_alloc_fresh_R7: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> (valid_q && tag_q == $past(dem_tag)
               && map_q == (MAP_W'(1) << {$past(dem_idx), 1'b0})));

endmodule

// File: rtl/zone_map_table.sv
module zone_map_table
  import zmt_pkg::*;
#(
  parameter int ADDR_W   = 40,
  parameter int OFS_W    = 6,
  parameter int IDX_W    = 8,
  parameter int NUM_MAPS = 52,
  localparam int TAG_W   = ADDR_W - OFS_W - IDX_W,
  localparam int MAP_W   = 2 * (1 << IDX_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dem_valid,
  input  logic [ADDR_W-1:0] dem_addr,
  input  logic              pf_valid,
  input  logic [ADDR_W-1:0] pf_addr,
  output logic              out_valid,
  output logic [TAG_W-1:0]  out_tag,
  output logic [IDX_W-1:0]  out_line,
  output logic [MAP_W-1:0]  out_map
);

  logic [TAG_W-1:0]          dem_tag, pf_tag;
  logic [IDX_W-1:0]          dem_idx, pf_idx;
  logic [NUM_MAPS-1:0]       hit_vec, victim_oh, alloc_vec, touch_oh;
  logic [NUM_MAPS*MAP_W-1:0] map_flat;
  logic [MAP_W-1:0]          sel_map;
  logic                      hit_any, miss;

  logic              out_valid_q;
  logic [TAG_W-1:0]  out_tag_q;
  logic [IDX_W-1:0]  out_line_q;
  logic [MAP_W-1:0]  out_map_q;

  assign dem_tag = dem_addr[ADDR_W-1 -: TAG_W];
  assign dem_idx = dem_addr[OFS_W +: IDX_W];
  assign pf_tag  = pf_addr[ADDR_W-1 -: TAG_W];
  assign pf_idx  = pf_addr[OFS_W +: IDX_W];

  assign hit_any   = |hit_vec;
  assign miss      = dem_valid && !hit_any;
  assign alloc_vec = victim_oh & {NUM_MAPS{miss}};
  assign touch_oh  = hit_any ? hit_vec : victim_oh;

  for (genvar g = 0; g < NUM_MAPS; g++) begin : g_ent
    zmt_entry #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .dem_valid(dem_valid),
      .dem_tag  (dem_tag),
      .dem_idx  (dem_idx),
      .pf_valid (pf_valid),
      .pf_tag   (pf_tag),
      .pf_idx   (pf_idx),
      .alloc    (alloc_vec[g]),
      .dem_hit  (hit_vec[g]),
      .map_nxt  (map_flat[g*MAP_W +: MAP_W])
    );
  end

  zmt_lru #(.N(NUM_MAPS)) u_lru (
    .clk        (clk),
    .rst_n      (rst_n),
    .touch_valid(dem_valid),
    .touch_oh   (touch_oh),
    .victim_oh  (victim_oh)
  );

  zmt_onehot_mux #(.N(NUM_MAPS), .W(MAP_W)) u_mux (
    .sel_oh   (touch_oh),
    .data_flat(map_flat),
    .data_out (sel_map)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_q <= 1'b0;
      out_tag_q   <= '0;
      out_line_q  <= '0;
      out_map_q   <= '0;
    end else begin
      out_valid_q <= dem_valid;
      if (dem_valid) begin
        out_tag_q  <= dem_tag;
        out_line_q <= dem_idx;
        out_map_q  <= sel_map;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_tag   = out_tag_q;
  assign out_line  = out_line_q;
  assign out_map   = out_map_q;

  // R7: a zone is never resident in two slots
  assert_single_hit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  // R3: every demand yields an output one cycle later
  assert_out_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dem_valid |=> out_valid);

  // R3: no output without a demand
  assert_out_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dem_valid |=> !out_valid);

  // R3: output carries the demanded line of the zone
  assert_out_fields_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dem_valid |=> (out_tag == $past(dem_tag) && out_line == $past(dem_idx)
                   && out_map[{out_line, 1'b0} +: 2] != ST_INIT));

endmodule

// File: tb/zone_map_table_bench.sv
`timescale 1ns/1ps
module zone_map_table_bench;

  localparam int ADDR_W = 16;
  localparam int OFS_W  = 2;
  localparam int IDX_W  = 3;
  localparam int NMAP   = 4;
  localparam int TAG_W  = ADDR_W - OFS_W - IDX_W;
  localparam int LINES  = 1 << IDX_W;
  localparam int MAP_W  = 2 * LINES;

  logic clk = 1'b0;
  logic rst_n;
  logic dem_valid, pf_valid;
  logic [ADDR_W-1:0] dem_addr, pf_addr;
  logic out_valid;
  logic [TAG_W-1:0] out_tag;
  logic [IDX_W-1:0] out_line;
  logic [MAP_W-1:0] out_map;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  zone_map_table #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .NUM_MAPS(NMAP)) u_zone_map_table (
    .clk(clk), .rst_n(rst_n),
    .dem_valid(dem_valid), .dem_addr(dem_addr),
    .pf_valid(pf_valid), .pf_addr(pf_addr),
    .out_valid(out_valid), .out_tag(out_tag), .out_line(out_line), .out_map(out_map)
  );

  // Reference model, built from the requirements.
  logic [TAG_W-1:0] m_tag [NMAP];
  bit               m_val [NMAP];
  logic [MAP_W-1:0] m_map [NMAP];
  int               lru_q [$];   // front = most recently demanded slot

  logic [TAG_W-1:0] exp_tag_q  [$];
  logic [IDX_W-1:0] exp_line_q [$];
  logic [MAP_W-1:0] exp_map_q  [$];
  string            exp_req_q  [$];

  function automatic logic [ADDR_W-1:0] mk(input logic [TAG_W-1:0] t, input logic [IDX_W-1:0] i);
    return {t, i, 2'b01};
  endfunction

  function automatic logic [1:0] dem_rule(input logic [1:0] s);
    if (s == 2'd0) return 2'd1;
    if (s == 2'd2) return 2'd3;
    return s;
  endfunction

  task automatic op(input bit dv, input logic [TAG_W-1:0] dt, input logic [IDX_W-1:0] di,
                    input bit pv, input logic [TAG_W-1:0] pt, input logic [IDX_W-1:0] pi,
                    input string req);
    int ps, ds;
    bit allocd;
    @(negedge clk);
    dem_valid = dv; dem_addr = mk(dt, di);
    pf_valid  = pv; pf_addr  = mk(pt, pi);
    ps = -1; ds = -1; allocd = 0;
    if (pv) for (int s = 0; s < NMAP; s++) if (m_val[s] && m_tag[s] == pt) ps = s;
    if (dv) begin
      for (int s = 0; s < NMAP; s++) if (m_val[s] && m_tag[s] == dt) ds = s;
      if (ds < 0) begin
        for (int s = NMAP - 1; s >= 0; s--) if (!m_val[s]) ds = s;
        if (ds < 0) ds = lru_q[lru_q.size() - 1];
        allocd = 1;
        m_val[ds] = 1; m_tag[ds] = dt; m_map[ds] = '0;
        if (ps == ds) ps = -1;
      end
      m_map[ds][2*di +: 2] = dem_rule(m_map[ds][2*di +: 2]);
      for (int k = 0; k < lru_q.size(); k++) if (lru_q[k] == ds) begin lru_q.delete(k); break; end
      lru_q.push_front(ds);
    end
    if (ps >= 0 && m_map[ps][2*pi +: 2] == 2'd0) m_map[ps][2*pi +: 2] = 2'd2;
    if (dv) begin
      exp_tag_q.push_back(dt); exp_line_q.push_back(di);
      exp_map_q.push_back(m_map[ds]); exp_req_q.push_back(req);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      dem_valid = 0; pf_valid = 0;
    end
  endtask

  // Monitor: compares each output against the oldest expected item.
  always @(negedge clk) begin
    #1;
    if (rst_n && out_valid) begin
      checks++;
      if (exp_map_q.size() == 0) begin
        fails++;
        $display("FAIL R3: unexpected output tag=%h actual valid=1 expected valid=0", out_tag);
      end else begin
        logic [TAG_W-1:0] et; logic [IDX_W-1:0] el; logic [MAP_W-1:0] em; string rq;
        et = exp_tag_q.pop_front(); el = exp_line_q.pop_front();
        em = exp_map_q.pop_front(); rq = exp_req_q.pop_front();
        if (out_tag !== et || out_line !== el || out_map !== em) begin
          fails++;
          $display("FAIL %s: actual tag=%h line=%0d map=%h expected tag=%h line=%0d map=%h",
                   rq, out_tag, out_line, out_map, et, el, em);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  localparam logic [TAG_W-1:0] ZA = 11'h0A1, ZB = 11'h0B2, ZC = 11'h0C3,
                               ZD = 11'h0D4, ZE = 11'h0E5, ZZ = 11'h07F;

  initial begin
    logic [15:0] lfsr;
    logic [TAG_W-1:0] zs [6];
    for (int s = 0; s < NMAP; s++) begin m_val[s] = 0; m_tag[s] = '0; m_map[s] = '0; end
    rst_n = 0; dem_valid = 0; pf_valid = 0; dem_addr = '0; pf_addr = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin fails++; $display("FAIL R1: out_valid in reset actual=%b expected=0", out_valid); end
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0) begin fails++; $display("FAIL R1: out_valid after reset actual=%b expected=0", out_valid); end

    // R1 R2 R3: empty table, first demand to zone A line 3
    op(1, ZA, 3, 0, '0, 0, "R1");
    op(1, ZA, 3, 0, '0, 0, "R5");
    op(0, '0, 0, 1, ZA, 5, "R6");
    op(1, ZA, 5, 0, '0, 0, "R4");
    op(0, '0, 0, 1, ZA, 3, "R6");
    op(1, ZA, 0, 0, '0, 0, "R6");
    op(0, '0, 0, 1, ZZ, 2, "R6");
    op(1, ZZ, 4, 0, '0, 0, "R6");
    op(1, ZA, 1, 1, ZA, 2, "R9");
    op(1, ZA, 6, 1, ZA, 6, "R9");
    op(1, ZB, 0, 0, '0, 0, "R7");
    op(1, ZC, 0, 0, '0, 0, "R7");
    op(1, ZD, 7, 1, ZZ, 1, "R10");
    op(1, ZA, 7, 0, '0, 0, "R8");
    op(0, '0, 0, 1, ZB, 5, "R8");
    op(1, ZE, 2, 0, '0, 0, "R8");
    op(1, ZB, 5, 0, '0, 0, "R7");
    op(1, ZZ, 1, 0, '0, 0, "R10");
    op(1, ZA, 0, 0, '0, 0, "R8");
    op(1, ZA, 2, 0, '0, 0, "R4");
    idle(2);

    // Mixed stream over six zones: R3 R4 R5 R6 R8 together
    zs[0] = ZA; zs[1] = ZB; zs[2] = ZC; zs[3] = ZD; zs[4] = ZE; zs[5] = ZZ;
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      logic [15:0] r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      r = lfsr;
      op(r[0], zs[r[3:1] % 6], r[6:4], r[7], zs[r[10:8] % 6], r[13:11], "R8");
    end
    idle(3);

    checks++;
    if (exp_map_q.size() != 0) begin
      fails++;
      $display("FAIL R3: outputs missing actual=%0d pending expected=0", exp_map_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule